// File: doc/BRIEF.md
# Byte-Lane Bus Access Splitter

This block sits between a processor-side load/store port and a 64-bit system bus. The bus carries only the qword address plus one byte enable per lane. The block takes a request with a byte address, a size of 1, 2, 4 or 8 bytes, a read/write flag and write data. It works out which byte lanes the access touches and places the write data on those lanes in little-endian order: the lowest-addressed byte goes to the lowest lane.

An access that runs past the end of its qword becomes two separate bus transactions, one per qword. Each has its own valid/ready handshake. For reads, the block collects the lanes returned by one or both halves and shifts them down into a right-justified result. Unrequested bytes in that result are zero.

A single response pulse marks completion of the whole request. The request port stays closed from acceptance until that pulse.

Top module: `bus_access_splitter`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0 and rsp_valid is 0.
- R2: bus_qaddr carries the request address shifted right by three. The second half of a split carries that value plus one. The three low address bits never appear on the bus.
- R3: req_size encodes the byte count as 0=1, 1=2, 2=4, 3=8. The first transaction enables lanes offset through min(offset+count, 8)-1, where offset is address bits 2:0 and bit k of bus_be is lane k. No other lane is enabled.
- R4: The request becomes two transactions exactly when offset+count exceeds 8. The second transaction enables lanes 0 through offset+count-9.
- R5: Write byte i of req_wdata (bits 8i+7:8i) goes out on lane (offset+i) mod 8. It is sent in the first transaction if offset+i < 8, and otherwise in the second.
- R6: While bus_valid is high and bus_ready is low, bus_valid, bus_qaddr, bus_be, bus_we and bus_wdata hold their values.
- R7: Read byte i of rsp_rdata equals the byte the bus returned on the lane of byte address addr+i. Bytes count and above are zero, as are bytes returned on lanes that were not enabled.
- R8: rsp_valid is high for exactly one cycle per request. It rises in the cycle after the last half completes: for a write, its handshake; for a read, its bus_rvalid.
- R9: req_ready is low from the cycle after a request is accepted until the cycle after rsp_valid. No second request is taken in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Log2 of byte count |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Right-justified write data |
| rsp_valid | output | 1 | Request completed (one cycle) |
| rsp_rdata | output | 64 | Right-justified read data, zero for writes |
| bus_valid | output | 1 | Bus transaction present |
| bus_ready | input | 1 | Bus accepts transaction |
| bus_qaddr | output | ADDR_W-3 | Qword address |
| bus_be | output | 8 | Byte-lane enables |
| bus_we | output | 1 | Bus write flag |
| bus_wdata | output | 64 | Lane-placed write data |
| bus_rvalid | input | 1 | Read data returned |
| bus_rdata | input | 64 | Returned lanes |

## Verification
The bench sweeps every size at every offset inside one qword. This covers all split boundaries, including 2-byte accesses at offset 7 and 8-byte accesses at offset 1. A wrong split test would give one transaction where two are needed, or issue an empty second half. Wrong mask arithmetic would enable the wrong lanes, which shows up as corrupted neighbouring bytes in the byte-addressed memory model.

The responder fills unenabled lanes with a junk value and stalls the ready line. Read merging that leaves these lanes unmasked, or that joins the halves in the wrong order, returns junk or swapped bytes. Upper bytes that are not zeroed show up as memory neighbours in the result.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAITR = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/bas_lane_map.sv
module bas_lane_map #(
  parameter int unsigned LANES = 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned DW = LANES * 8
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  input  logic [DW-1:0]    wdata,
  output logic [LANES-1:0] keep,
  output logic [LANES-1:0] be_lo,
  output logic [LANES-1:0] be_hi,
  output logic [DW-1:0]    wd_lo,
  output logic [DW-1:0]    wd_hi,
  output logic             split
);
  // Unshifted mask of the requested byte count
  function automatic logic [LANES-1:0] count_mask(input logic [1:0] sz);
    logic [LANES-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      if (i < (1 << sz)) m[i] = 1'b1;
    return m;
  endfunction

  logic [2*LANES-1:0] wide_be;
  logic [2*DW-1:0]    wide_d;

  assign keep    = count_mask(size);
  assign wide_be = {{LANES{1'b0}}, keep} << off;
  assign wide_d  = {{DW{1'b0}}, wdata} << {off, 3'b000};
  assign be_lo   = wide_be[LANES-1:0];
  assign be_hi   = wide_be[2*LANES-1:LANES];
  assign wd_lo   = wide_d[DW-1:0];
  assign wd_hi   = wide_d[2*DW-1:DW];
  assign split   = |be_hi;
endmodule

// File: rtl/bas_read_merge.sv
module bas_read_merge #(
  parameter int unsigned LANES = 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned DW = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cap_lo,
  input  logic             cap_hi,
  input  logic [DW-1:0]    rdata,
  input  logic [LANES-1:0] be,
  input  logic [OFF_W-1:0] off,
  input  logic [LANES-1:0] keep,
  output logic [DW-1:0]    result
);
  function automatic logic [DW-1:0] lane_expand(input logic [LANES-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction

  logic [2*DW-1:0] acc_q;
  logic [2*DW-1:0] shifted;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc_q <= '0;
    else begin
      if (cap_lo) acc_q[DW-1:0]    <= rdata & lane_expand(be);
      if (cap_hi) acc_q[2*DW-1:DW] <= rdata & lane_expand(be);
    end
  end

  assign shifted = acc_q >> {off, 3'b000};
  assign result  = shifted[DW-1:0] & lane_expand(keep);
endmodule

// File: rtl/bas_seq_ctrl.sv
module bas_seq_ctrl
  import bas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic we,
  input  logic split,
  input  logic bus_ready,
  input  logic bus_rvalid,
  output logic req_ready,
  output logic accept,
  output logic bus_valid,
  output logic half,
  output logic cap_lo,
  output logic cap_hi,
  output logic rsp_valid
);
  seq_state_t st_q, st_d;
  logic half_d;
  logic more;

  assign more      = split && !half;
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign bus_valid = (st_q == ST_ISSUE);
  assign rsp_valid = (st_q == ST_RESP);
  assign cap_lo    = (st_q == ST_WAITR) && bus_rvalid && !half;
  assign cap_hi    = (st_q == ST_WAITR) && bus_rvalid && half;

  always_comb begin
    st_d   = st_q;
    half_d = half;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin st_d = ST_ISSUE; half_d = 1'b0; end
      ST_ISSUE:
        if (bus_ready) begin
          if (!we) st_d = ST_WAITR;
          else if (more) half_d = 1'b1;
          else st_d = ST_RESP;
        end
      ST_WAITR:
        if (bus_rvalid) begin
          if (more) begin st_d = ST_ISSUE; half_d = 1'b1; end
          else st_d = ST_RESP;
        end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      half <= 1'b0;
    end else begin
      st_q <= st_d;
      half <= half_d;
    end
  end

  a_r6_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid);
  a_r9_closed_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r4_half_needs_split: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> split);
endmodule

// File: rtl/bus_access_splitter.sv
module bus_access_splitter #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned DW    = LANES * 8,
  localparam int unsigned QA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [QA_W-1:0]   bus_qaddr,
  output logic [LANES-1:0]  bus_be,
  output logic              bus_we,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_rvalid,
  input  logic [DW-1:0]     bus_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              we_q;
  logic [DW-1:0]     wdata_q;

  logic              accept, half, cap_lo, cap_hi, split;
  logic [LANES-1:0]  keep, be_lo, be_hi;
  logic [DW-1:0]     wd_lo, wd_hi, merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      size_q  <= req_size;
      we_q    <= req_we;
      wdata_q <= req_wdata;
    end
  end

  bas_lane_map #(.LANES(LANES)) map_i (
    .off(addr_q[OFF_W-1:0]), .size(size_q), .wdata(wdata_q),
    .keep(keep), .be_lo(be_lo), .be_hi(be_hi),
    .wd_lo(wd_lo), .wd_hi(wd_hi), .split(split)
  );

  bas_seq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .we(we_q),
    .split(split), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
    .req_ready(req_ready), .accept(accept), .bus_valid(bus_valid),
    .half(half), .cap_lo(cap_lo), .cap_hi(cap_hi), .rsp_valid(rsp_valid)
  );

  bas_read_merge #(.LANES(LANES)) merge_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .cap_lo(cap_lo),
    .cap_hi(cap_hi), .rdata(bus_rdata), .be(bus_be),
    .off(addr_q[OFF_W-1:0]), .keep(keep), .result(merged)
  );

  assign bus_qaddr = addr_q[ADDR_W-1:OFF_W] + QA_W'(half);
  assign bus_be    = half ? be_hi : be_lo;
  assign bus_wdata = half ? wd_hi : wd_lo;
  assign bus_we    = we_q;
  assign rsp_rdata = we_q ? '0 : merged;

  a_r3_lanes_present: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_be != '0);
  a_r4_second_from_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && half |-> bus_be[0]);
  a_r6_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> $stable(bus_be) && $stable(bus_qaddr)
                               && $stable(bus_wdata) && $stable(bus_we));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid);
endmodule

// File: tb/bus_access_splitter_tb_top.sv
module bus_access_splitter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0, rsp_rdata, bus_wdata, bus_rdata = '0;
  logic        rsp_valid, bus_valid, bus_ready = 1'b0, bus_we, bus_rvalid = 1'b0;
  logic [28:0] bus_qaddr;
  logic [7:0]  bus_be;

  bus_access_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_we(req_we),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_qaddr(bus_qaddr),
    .bus_be(bus_be), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mem [0:63];

  // Bus responder: capture handshake at the edge, act at the falling edge
  logic hs_p = 1'b0;
  logic [28:0] qa_p;
  logic [7:0]  be_p;
  logic        we_p;
  logic [63:0] wd_p;
  int log_n = 0;
  logic [7:0]  log_be [0:3];
  logic [28:0] log_qa [0:3];
  int tick = 0;

  always @(posedge clk) begin
    hs_p <= bus_valid && bus_ready;
    qa_p <= bus_qaddr;
    be_p <= bus_be;
    we_p <= bus_we;
    wd_p <= bus_wdata;
  end

  always @(negedge clk) begin
    bus_rvalid = 1'b0;
    if (hs_p) begin
      if (log_n < 4) begin
        log_be[log_n] = be_p;
        log_qa[log_n] = qa_p;
      end
      log_n = log_n + 1;
      for (int l = 0; l < 8; l++) begin
        if (we_p && be_p[l]) mem[(int'(qa_p) * 8 + l) % 64] = wd_p[l*8 +: 8];
        bus_rdata[l*8 +: 8] = be_p[l] ? mem[(int'(qa_p) * 8 + l) % 64] : 8'hEE;
      end
      if (!we_p) bus_rvalid = 1'b1;
    end
    bus_ready = (tick % 3) != 1;
    tick = tick + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input int a, input int sz, input bit we,
                        input logic [63:0] d, output logic [63:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    log_n = 0;
    req_valid = 1'b1; req_addr = a; req_size = sz[1:0]; req_we = we; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready low after accept", {63'd0, req_ready}, 64'd0);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R8 response one cycle", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, rd, expm;
    int n, base, exp_n;
    logic [7:0] e0, e1;
    for (int i = 0; i < 64; i++) mem[i] = 8'h40 + 8'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(req_ready && !bus_valid && !rsp_valid, "R1 reset state",
        {61'd0, req_ready, bus_valid, rsp_valid}, 64'h4);
    rst_n = 1'b1;
    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 8; off++) begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h40 + 8'(i);
        n = 1 << sz;
        base = 16 + off;
        v = 64'hF1E2D3C4B5A69788 ^ (64'h0123456789ABCDEF * (sz * 8 + off + 1));
        e0 = '0; e1 = '0;
        for (int i = 0; i < n; i++)
          if (off + i < 8) e0[off + i] = 1'b1; else e1[off + i - 8] = 1'b1;
        exp_n = (off + n > 8) ? 2 : 1;
        expm = '0;
        for (int i = 0; i < n; i++) expm[i*8 +: 8] = v[i*8 +: 8];
        // write
        do_req(base, sz, 1'b1, v, rd);
        chk(log_n == exp_n, "R4 write split count", 64'(log_n), 64'(exp_n));
        chk(log_be[0] == e0, "R3 first enables", 64'(log_be[0]), 64'(e0));
        chk(log_qa[0] == 29'(base / 8), "R2 first qaddr", 64'(log_qa[0]), 64'(base / 8));
        if (exp_n == 2) begin
          chk(log_be[1] == e1, "R4 second enables", 64'(log_be[1]), 64'(e1));
          chk(log_qa[1] == 29'(base / 8 + 1), "R2 second qaddr",
              64'(log_qa[1]), 64'(base / 8 + 1));
        end
        for (int i = 0; i < n; i++)
          chk(mem[base + i] == v[i*8 +: 8], "R5 write byte placement",
              64'(mem[base + i]), 64'(v[i*8 +: 8]));
        chk(mem[base - 1] == 8'h40 + 8'(base - 1), "R3 lower neighbour kept",
            64'(mem[base - 1]), 64'(8'h40 + 8'(base - 1)));
        chk(mem[base + n] == 8'h40 + 8'(base + n), "R3 upper neighbour kept",
            64'(mem[base + n]), 64'(8'h40 + 8'(base + n)));
        // read back
        do_req(base, sz, 1'b0, 64'd0, rd);
        chk(log_n == exp_n, "R4 read split count", 64'(log_n), 64'(exp_n));
        chk(rd == expm, "R7 merged read data", rd, expm);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule